// File: doc/BRIEF.md
# Serial Register Write Controller

This block sits on the host side of a three-line serial programming link (serial clock, serial data, latch enable). A client hands it a 4-bit register address and a 28-bit payload over a valid/ready handshake. The controller packs them into one 32-bit word, with the address in the low nibble. It shifts the word out least-significant bit first, with the serial clock generated from the much faster system clock, and then pulses latch enable so that the target device transfers the word into the addressed register.

Each interval on the link is a parameter in nanoseconds. These intervals are data setup and hold around the rising serial edge, the high and low phase widths, the serial clock period, the gap from the last rising edge to the latch, the latch width and the recovery after the latch. Each is rounded up to whole system clock cycles at elaboration. The data line moves only together with a falling serial clock edge or when a new word is accepted. The serial clock rests low while idle. Ready stays low for the whole transfer, including recovery, and a one-cycle done pulse marks the moment the next write may start.

Top module: `ser_wr_ctrl`

## Requirements
- R1: After reset and whenever idle, ser_clk and ser_le are 0, wr_ready is 1 and wr_done is 0.
- R2: The transmitted word is {wr_data, wr_addr}: bit k of that word is on ser_data at the k-th rising ser_clk edge, so the address occupies bits 0 to 3 and the word goes out least-significant bit first.
- R3: Every high phase of ser_clk lasts HI = max(ceil(t_high/Tsys), ceil(t_hold/Tsys)) cycles. Every low phase inside a word lasts LO = max(ceil(t_low/Tsys), ceil(t_setup/Tsys), ceil(t_period/Tsys) - HI) cycles. The first rising edge comes LO cycles after acceptance. With the defaults HI=2 and LO=3.
- R4: ser_data changes only in the cycle in which ser_clk falls or in the cycle after a write is accepted.
- R5: Each write produces exactly 32 rising ser_clk edges.
- R6: ser_le rises HI + ceil(t_clk_to_latch/Tsys) cycles after the last rising ser_clk edge, which is 4 cycles with the defaults, and ser_clk is low while ser_le is high.
- R7: ser_le stays high for exactly ceil(t_latch/Tsys) cycles (5 by default).
- R8: wr_ready is low from the cycle after acceptance until recovery, REC = ceil(t_recover/Tsys) cycles (7 by default), has elapsed after ser_le falls. wr_done is high for exactly one cycle, the first cycle in which wr_ready is high again. Acceptance to done is 32*(HI+LO)+C2L+LAT+REC cycles (174 by default).
- R9: While wr_ready is low, wr_valid, wr_addr and wr_data are ignored: the word being sent is unchanged and no extra write follows.
- R10: A write held pending during a transfer is accepted one cycle after wr_done, so the next word's data appears REC+1 cycles after ser_le falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Controller can accept a write |
| wr_addr | input | 4 | Target register address |
| wr_data | input | 28 | Register payload |
| ser_clk | output | 1 | Serial clock to the device |
| ser_data | output | 1 | Serial data to the device |
| ser_le | output | 1 | Latch enable to the device |
| wr_done | output | 1 | One-cycle pulse when the write and its recovery are complete |

## Verification
All serial timing follows from the acceptance edge. The first rise is due LO cycles later, each later phase HI or LO cycles after the previous edge, the latch HI+C2L cycles after the last rise, and done 174 cycles after acceptance with the defaults. The bench samples every output on the falling system clock edge. It stamps each observed transition with the system edge count and compares the measured distances with values it derives from the nanosecond figures with its own rounding. It detects acceptance as a fall of wr_ready, never from its own stimulus, so no check depends on the order of processes at an edge.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH,
    ST_RECOV
  } wr_state_t;

  // Round a nanosecond interval up to whole system cycles, never below one.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned sys_ns);
    int unsigned c;
    c = (ns + sys_ns - 1) / sys_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // High phase must cover both the minimum high width and the data hold,
  // because data only moves at the falling edge.
  function automatic int unsigned hi_cycles(int unsigned hi_ns, int unsigned hold_ns,
                                            int unsigned sys_ns);
    return max2(ns_to_cyc(hi_ns, sys_ns), ns_to_cyc(hold_ns, sys_ns));
  endfunction

  // Low phase covers the low width, the data setup and the rest of the period.
  function automatic int unsigned lo_cycles(int unsigned lo_ns, int unsigned su_ns,
                                            int unsigned per_ns, int unsigned hi_c,
                                            int unsigned sys_ns);
    int unsigned per_c;
    int unsigned rest;
    per_c = ns_to_cyc(per_ns, sys_ns);
    rest  = (per_c > hi_c) ? per_c - hi_c : 1;
    return max2(max2(ns_to_cyc(lo_ns, sys_ns), ns_to_cyc(su_ns, sys_ns)), rest);
  endfunction

endpackage

// File: rtl/swc_phase_timer.sv
module swc_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // A phase of N cycles is loaded as N-1 and ends when the count reaches zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_len - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/swc_shifter.sv
module swc_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              out_bit,
  output logic              last_bit
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_word;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[WORD_W-1:1]};
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign out_bit  = sh_q[0];
  assign last_bit = (idx_q == IDX_W'(WORD_W - 1));
endmodule

// File: rtl/swc_seq_fsm.sv
module swc_seq_fsm import ser_wr_pkg::*; #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned HI_C  = 2,
  parameter int unsigned LO_C  = 3,
  parameter int unsigned C2L_C = 2,
  parameter int unsigned LAT_C = 5,
  parameter int unsigned REC_C = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             tmr_exp,
  input  logic             last_bit,
  output logic             req_ready,
  output logic             acc_evt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             sh_shift,
  output logic             sclk_q,
  output logic             le_q,
  output logic             done_q
);
  wr_state_t st_q, st_d;

  always_comb begin
    st_d     = st_q;
    acc_evt  = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        acc_evt  = 1'b1;
        st_d     = ST_LOW;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(LO_C);
      end
      ST_LOW: if (tmr_exp) begin
        st_d     = ST_HIGH;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(HI_C);
      end
      ST_HIGH: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          st_d    = ST_GAP;
          tmr_len = CNT_W'(C2L_C);
        end else begin
          st_d     = ST_LOW;
          tmr_len  = CNT_W'(LO_C);
          sh_shift = 1'b1;
        end
      end
      ST_GAP: if (tmr_exp) begin
        st_d     = ST_LATCH;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(LAT_C);
      end
      ST_LATCH: if (tmr_exp) begin
        st_d     = ST_RECOV;
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(REC_C);
      end
      ST_RECOV: if (tmr_exp) begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= (st_d == ST_HIGH);
      le_q   <= (st_d == ST_LATCH);
      done_q <= (st_q == ST_RECOV) && tmr_exp;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/ser_wr_ctrl.sv
module ser_wr_ctrl import ser_wr_pkg::*; #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 28,
  parameter int unsigned SYS_NS   = 10,
  parameter int unsigned T_SU_NS  = 20,
  parameter int unsigned T_HD_NS  = 20,
  parameter int unsigned T_HI_NS  = 20,
  parameter int unsigned T_LO_NS  = 20,
  parameter int unsigned T_PER_NS = 50,
  parameter int unsigned T_C2L_NS = 20,
  parameter int unsigned T_LAT_NS = 50,
  parameter int unsigned T_REC_NS = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le,
  output logic              wr_done
);
  localparam int unsigned WORD_W = ADDR_W + DATA_W;
  localparam int unsigned HI_C   = hi_cycles(T_HI_NS, T_HD_NS, SYS_NS);
  localparam int unsigned LO_C   = lo_cycles(T_LO_NS, T_SU_NS, T_PER_NS, HI_C, SYS_NS);
  localparam int unsigned C2L_C  = ns_to_cyc(T_C2L_NS, SYS_NS);
  localparam int unsigned LAT_C  = ns_to_cyc(T_LAT_NS, SYS_NS);
  localparam int unsigned REC_C  = ns_to_cyc(T_REC_NS, SYS_NS);
  localparam int unsigned MAX_C  = max2(max2(HI_C, LO_C), max2(max2(C2L_C, LAT_C), REC_C));
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

  // Named internal events for the bound checker.
  logic             acc_evt;
  logic             tmr_exp;
  logic             last_bit;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             sh_shift;
  logic [15:0]      lat_len_w;
  logic [WORD_W-1:0] word_in;

  assign word_in   = {wr_data, wr_addr};
  assign lat_len_w = 16'(LAT_C);

  swc_seq_fsm #(
    .CNT_W (CNT_W),
    .HI_C  (HI_C),
    .LO_C  (LO_C),
    .C2L_C (C2L_C),
    .LAT_C (LAT_C),
    .REC_C (REC_C)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (wr_valid),
    .tmr_exp   (tmr_exp),
    .last_bit  (last_bit),
    .req_ready (wr_ready),
    .acc_evt   (acc_evt),
    .tmr_load  (tmr_load),
    .tmr_len   (tmr_len),
    .sh_shift  (sh_shift),
    .sclk_q    (ser_clk),
    .le_q      (ser_le),
    .done_q    (wr_done)
  );

  swc_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .expire   (tmr_exp)
  );

  swc_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_evt),
    .load_word (word_in),
    .shift     (sh_shift),
    .out_bit   (ser_data),
    .last_bit  (last_bit)
  );
endmodule

// File: rtl/ser_wr_ctrl_chk.sv
module ser_wr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_clk,
  input logic        ser_data,
  input logic        ser_le,
  input logic        wr_ready,
  input logic        wr_done,
  input logic        acc_evt,
  input logic [15:0] lat_len
);
  logic [15:0] le_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      le_run_q <= '0;
    else if (ser_le) le_run_q <= le_run_q + 16'd1;
    else             le_run_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!ser_clk && !ser_le));

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> ($fell(ser_clk) || $past(acc_evt)));

  p_clk_low_in_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);

  p_latch_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_le) |-> (le_run_q == lat_len));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !wr_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_done_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> wr_ready);
endmodule

bind ser_wr_ctrl ser_wr_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_le   (ser_le),
  .wr_ready (wr_ready),
  .wr_done  (wr_done),
  .acc_evt  (acc_evt),
  .lat_len  (lat_len_w)
);

// File: tb/ser_wr_ctrl_bench.sv
`timescale 1ns/1ps
module ser_wr_ctrl_bench;
  localparam int SYS = 10;

  function automatic int cyc_of(int ns);
    int c;
    c = ns / SYS;
    if (ns % SYS != 0) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EHI  = 2;   // recomputed below
  int e_hi, e_lo, e_c2l, e_lat, e_rec, e_total;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic wr_ready, ser_clk, ser_data, ser_le, wr_done;

  always #5 clk = ~clk;

  ser_wr_ctrl u_ser_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .wr_done(wr_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  bit p_sclk = 0, p_data = 0, p_le = 0, p_ready = 1;
  int acc_cyc = 0, last_rise = 0, fall_cyc = 0, le_rise = 0, le_fall = -1000;
  int rise_cnt = 0, hi_bad = 0, lo_bad = 0, data_bad = 0, first_low = 0;
  int le_w = 0, clk_in_le = 0, busy_cnt = 0, acc_gap = 0, acc_total = 0;
  logic [31:0] word_cap = '0;
  // snapshot at done
  int writes_done = 0;
  logic [31:0] s_word;
  int s_rise, s_hi_bad, s_lo_bad, s_data_bad, s_first_low, s_c2l, s_le_w;
  int s_clk_in_le, s_busy, s_lat, s_gap;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit accepted, rise, fall;
      accepted = p_ready && !wr_ready;
      rise = ser_clk && !p_sclk;
      fall = !ser_clk && p_sclk;
      if (accepted) begin
        acc_gap = cyc - le_fall;
        acc_cyc = cyc; rise_cnt = 0; hi_bad = 0; lo_bad = 0; data_bad = 0;
        clk_in_le = 0; busy_cnt = 0; word_cap = '0; acc_total++;
      end
      if (rise) begin
        if (rise_cnt == 0) first_low = cyc - acc_cyc;
        else if (cyc - fall_cyc != e_lo) lo_bad++;
        word_cap = {ser_data, word_cap[31:1]};
        rise_cnt++;
        last_rise = cyc;
      end
      if (fall) begin
        if (cyc - last_rise != e_hi) hi_bad++;
        fall_cyc = cyc;
      end
      if (ser_data != p_data && !fall && !accepted) data_bad++;
      if (ser_le && !p_le) le_rise = cyc;
      if (!ser_le && p_le) begin le_fall = cyc; le_w = cyc - le_rise; end
      if (ser_le && ser_clk) clk_in_le++;
      if (!wr_ready) busy_cnt++;
      if (wr_done) begin
        s_word = word_cap; s_rise = rise_cnt; s_hi_bad = hi_bad; s_lo_bad = lo_bad;
        s_data_bad = data_bad; s_first_low = first_low; s_c2l = le_rise - last_rise;
        s_le_w = le_w; s_clk_in_le = clk_in_le; s_busy = busy_cnt;
        s_lat = cyc - acc_cyc; s_gap = acc_gap;
        writes_done++;
      end
      p_sclk = ser_clk; p_data = ser_data; p_le = ser_le; p_ready = wr_ready;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [3:0] a, input logic [27:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (writes_done < n) @(negedge clk);
    #1;
  endtask

  task automatic check_write(input logic [3:0] a, input logic [27:0] d, input string tag);
    logic [31:0] exp_w;
    exp_w = {d, a};
    check(s_word == exp_w, "R2", {tag, " word"}, s_word, exp_w);
    check(s_word[3:0] == a, "R2", {tag, " address nibble"}, s_word[3:0], a);
    check(s_rise == 32, "R5", {tag, " rising edges"}, s_rise, 32);
    check(s_first_low == e_lo, "R3", {tag, " first low"}, s_first_low, e_lo);
    check(s_hi_bad == 0 && s_lo_bad == 0, "R3", {tag, " phase widths"},
          s_hi_bad + s_lo_bad, 0);
    check(s_data_bad == 0, "R4", {tag, " data moves off fall"}, s_data_bad, 0);
    check(s_c2l == e_hi + e_c2l, "R6", {tag, " rise to latch"}, s_c2l, e_hi + e_c2l);
    check(s_clk_in_le == 0, "R6", {tag, " clock in latch"}, s_clk_in_le, 0);
    check(s_le_w == e_lat, "R7", {tag, " latch width"}, s_le_w, e_lat);
    check(s_lat == e_total, "R8", {tag, " done latency"}, s_lat, e_total);
    check(s_busy == e_total, "R8", {tag, " ready low span"}, s_busy, e_total);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(wr_ready == 1'b1, "R1", "ready after reset", wr_ready, 1);
    check(ser_clk == 1'b0, "R1", "sclk after reset", ser_clk, 0);
    check(ser_le == 1'b0, "R1", "le after reset", ser_le, 0);
    check(wr_done == 1'b0, "R1", "done after reset", wr_done, 0);
  endtask

  task automatic t_single(input logic [3:0] a, input logic [27:0] d, input string tag);
    int n;
    n = writes_done;
    send(a, d);
    wait_writes(n + 1);
    check_write(a, d, tag);
    @(negedge clk); @(negedge clk);
    check(wr_done == 1'b0, "R8", {tag, " done is one cycle"}, wr_done, 0);
    check(wr_ready && !ser_clk && !ser_le, "R1", {tag, " idle after write"},
          {wr_ready, ser_clk, ser_le}, 3'b100);
  endtask

  task automatic t_busy_ignore();
    int n, a0;
    n = writes_done; a0 = acc_total;
    send(4'h6, 28'h1234567);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wr_addr = 4'(i); wr_data = 28'(i * 32'h00F0F0F); wr_valid = (i % 3 == 0);
    end
    @(negedge clk); wr_valid = 1'b0;
    wait_writes(n + 1);
    check(s_word == {28'h1234567, 4'h6}, "R9", "word kept while busy",
          s_word, {28'h1234567, 4'h6});
    repeat (20) @(negedge clk);
    check(acc_total == a0 + 1, "R9", "no extra write accepted", acc_total, a0 + 1);
    check(writes_done == n + 1, "R9", "no extra done", writes_done, n + 1);
  endtask

  task automatic t_back_to_back();
    int n;
    n = writes_done;
    send(4'h9, 28'h0C0FFEE);
    @(negedge clk); wr_addr = 4'h2; wr_data = 28'h7654321; wr_valid = 1'b1;
    wait_writes(n + 1);
    check_write(4'h9, 28'h0C0FFEE, "R10 first");
    @(negedge clk);
    check(wr_ready == 1'b0, "R10", "pending write taken after done", wr_ready, 0);
    wr_valid = 1'b0;
    wait_writes(n + 2);
    check_write(4'h2, 28'h7654321, "R10 second");
    check(s_gap == e_rec + 1, "R10", "latch fall to next accept", s_gap, e_rec + 1);
  endtask

  initial begin
    e_hi    = mx(cyc_of(20), cyc_of(20));
    e_lo    = mx(mx(cyc_of(20), cyc_of(20)), cyc_of(50) - e_hi);
    e_c2l   = cyc_of(20);
    e_lat   = cyc_of(50);
    e_rec   = cyc_of(70);
    e_total = 32 * (e_hi + e_lo) + e_c2l + e_lat + e_rec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(4'hA, 28'h5A5A5A5, "R2 mixed");
    t_single(4'h0, 28'h0000000, "R2 zeros");
    t_single(4'hF, 28'hFFFFFFF, "R2 ones");
    t_single(4'h3, 28'h8000001, "R2 edges");
    t_busy_ignore();
    t_back_to_back();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule